// File: doc/BRIEF.md
# Accumulator and File Register Execute Unit

This block executes one 14-bit instruction word per clock edge. It works on an 8-bit working register W, a 128-byte file register array and a three-bit flag set: carry C, digit carry DC and zero Z. The word arrives already fetched, together with a strobe that marks it valid. Byte-oriented operations read one file byte and combine it with W. A destination bit routes the result either to W or back into the same file byte. Bit-oriented operations clear, set or test a single bit of a file byte. Literal operations combine an 8-bit constant from the word with W. Each operation updates its own subset of the flags.

The test operations can raise a skip request. These are decrement or increment with skip on zero, and the two bit tests. A small two-state control machine handles it. In RUN every valid word executes. A word that requests a skip moves the machine to SQUASH (transition RUN->SQUASH). The next valid word is then discarded and the machine goes back (transition SQUASH->RUN). Flag bits read and write through file address 3, so software-style code can touch them as an ordinary byte. A second, combinational read port lets the surrounding logic observe any file byte.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, W is 0x00, all flags are 0, skip_req is 0, every file byte reads 0x00, and the control machine is in RUN.
- R2: A byte word has the form 00 oooo d fffffff. The 4-bit operation is in bits 11:8, d is bit 7 and the file address is bits 6:0. With d=0 the result is written to W; with d=1 it is written to file byte f, and W is left alone. Operation 0001 clears (Z=1), and operation 0000 with d=1 copies W into f.
- R3: Add is 0111 (f+W) and literal 111x (k+W). Subtract is 0010 (f-W) and literal 110x (k-W). Each updates C, DC and Z. C is the carry out of bit 7, and for subtraction C=1 means no borrow. DC is the carry out of bit 3, computed the same way.
- R4: The following update only Z, which is set when the result is zero: AND 0101, inclusive OR 0100, exclusive OR 0110, complement 1001, increment 1010, decrement 0011, move f 1000 and clear 0001.
- R5: Rotate right (1100) and rotate left (1101) pass through C. The bit shifted out lands in C and the old C fills the vacated end, and only C changes. Nibble swap (1110), copy-W (0000, d=1) and the two skip-on-zero forms (1011 decrement, 1111 increment) change no flag.
- R6: A bit word has the form 01 oo bbb fffffff. The bit number b is in bits 9:7, and oo is in bits 11:10. oo=00 clears bit b of f, 01 sets it, 10 requests a skip when the bit is 0, and 11 requests a skip when the bit is 1. No flag changes, except through address 3.
- R7: A literal word has the form 11 oooo kkkkkkkk and writes only W. 00xx moves k with no flag change. 1000 is OR, 1001 is AND and 1010 is XOR, each updating Z only.
- R8: skip_req is high for exactly the one cycle after a word whose skip condition held. The condition for the skip-on-zero forms is a zero result, and for the bit tests it is the tested bit state.
- R9: The first valid word after a skip request is discarded and changes no state. The word after it executes normally.
- R10: A cycle with instr_valid low changes no state. These words also change no state: any word with top bits 10, byte operation 0000 with d=0, and literal 01xx or 1011.
- R11: File address 3 reads as {5'b0, Z, DC, C}. A write to it loads those three bits, but the flags that the same instruction itself updates take the newly computed values.
- R12: rd_data shows the current content of file byte rd_addr combinationally, with address 3 read as the flag byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | The word on instr is to be executed this edge |
| instr | input | 14 | Instruction word |
| rd_addr | input | 7 | File address observed on rd_data |
| rd_data | output | 8 | Content of file byte rd_addr |
| w_out | output | 8 | Working register W |
| flags_out | output | 3 | {Z, DC, C} |
| skip_req | output | 1 | Skip request raised by the previous word |

## Verification
The assertions rely on one assumption about the inputs: instr is meaningful only when instr_valid is high, and any 14-bit value may appear there, including unused encodings. Under that assumption they check that idle and discarded cycles hold W and the flags, and that a skip request always coincides with SQUASH. The stimulus draws words from every encoding group, unused ones included, and confines file addresses to a low window that contains address 3. This produces frequent flag-byte writes, zero results and skips. The strobe is dropped at random so that idle cycles also fall inside a pending discard.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int XLEN    = 8;
    localparam int FADDR_W = 7;
    localparam int BSEL_W  = 3;
    localparam int IW      = 14;

    typedef enum logic [4:0] {
        OP_NOP, OP_MOVWF, OP_CLR, OP_SUB, OP_DEC, OP_IOR, OP_AND, OP_XOR,
        OP_ADD, OP_MOV, OP_COM, OP_INC, OP_DECSZ, OP_RR, OP_RL, OP_SWAP,
        OP_INCSZ, OP_BCLR, OP_BSET, OP_BTSTC, OP_BTSTS,
        OP_LMOV, OP_LIOR, OP_LAND, OP_LXOR, OP_LSUB, OP_LADD
    } op_e;

    typedef struct packed {
        op_e                op;
        logic               to_file;
        logic [FADDR_W-1:0] faddr;
        logic [BSEL_W-1:0]  bsel;
        logic [XLEN-1:0]    lit;
    } dec_t;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_RUN,
        ST_SQUASH
    } ctl_state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_exec_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);

    always_comb begin
        dec         = '0;
        dec.op      = OP_NOP;
        dec.faddr   = instr[FADDR_W-1:0];
        dec.bsel    = instr[FADDR_W+BSEL_W-1:FADDR_W];
        dec.lit     = instr[XLEN-1:0];
        dec.to_file = 1'b0;
        unique case (instr[IW-1:IW-2])
            2'b00: begin
                dec.to_file = instr[7];
                unique case (instr[11:8])
                    4'h0: dec.op = instr[7] ? OP_MOVWF : OP_NOP;
                    4'h1: dec.op = OP_CLR;
                    4'h2: dec.op = OP_SUB;
                    4'h3: dec.op = OP_DEC;
                    4'h4: dec.op = OP_IOR;
                    4'h5: dec.op = OP_AND;
                    4'h6: dec.op = OP_XOR;
                    4'h7: dec.op = OP_ADD;
                    4'h8: dec.op = OP_MOV;
                    4'h9: dec.op = OP_COM;
                    4'hA: dec.op = OP_INC;
                    4'hB: dec.op = OP_DECSZ;
                    4'hC: dec.op = OP_RR;
                    4'hD: dec.op = OP_RL;
                    4'hE: dec.op = OP_SWAP;
                    4'hF: dec.op = OP_INCSZ;
                    default: dec.op = OP_NOP;
                endcase
                if (dec.op == OP_NOP) begin
                    dec.to_file = 1'b0;
                end
            end
            2'b01: begin
                dec.to_file = ~instr[11];
                unique case (instr[11:10])
                    2'b00:   dec.op = OP_BCLR;
                    2'b01:   dec.op = OP_BSET;
                    2'b10:   dec.op = OP_BTSTC;
                    default: dec.op = OP_BTSTS;
                endcase
            end
            2'b11: begin
                dec.to_file = 1'b0;
                casez (instr[11:8])
                    4'b00??: dec.op = OP_LMOV;
                    4'b1000: dec.op = OP_LIOR;
                    4'b1001: dec.op = OP_LAND;
                    4'b1010: dec.op = OP_LXOR;
                    4'b110?: dec.op = OP_LSUB;
                    4'b111?: dec.op = OP_LADD;
                    default: dec.op = OP_NOP;
                endcase
            end
            default: begin
                dec.op      = OP_NOP;
                dec.to_file = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_exec_pkg::*;
(
    input  op_e               op,
    input  logic [BSEL_W-1:0] bsel,
    input  logic [XLEN-1:0]   lit,
    input  logic [XLEN-1:0]   fval,
    input  logic [XLEN-1:0]   wval,
    input  logic              c_in,
    output logic [XLEN-1:0]   res,
    output flags_t            nflags,
    output flags_t            upd,
    output logic              wr_res,
    output logic              skip
);

    localparam int HALF = XLEN / 2;

    logic [XLEN:0]     sum;
    logic [HALF:0]     lo;
    logic [XLEN-1:0]   a;
    logic [XLEN-1:0]   bmask;
    logic              is_lit;

    assign is_lit = (op == OP_LSUB) || (op == OP_LADD) || (op == OP_LMOV) ||
                    (op == OP_LIOR) || (op == OP_LAND) || (op == OP_LXOR);
    assign a      = is_lit ? lit : fval;
    assign bmask  = XLEN'(1) << bsel;

    always_comb begin
        res       = fval;
        sum       = '0;
        lo        = '0;
        upd       = '0;
        nflags    = '0;
        wr_res    = 1'b1;
        skip      = 1'b0;
        unique case (op)
            OP_NOP:   wr_res = 1'b0;
            OP_MOVWF: res = wval;
            OP_CLR: begin
                res   = '0;
                upd.z = 1'b1;
            end
            OP_ADD, OP_LADD: begin
                sum      = {1'b0, a} + {1'b0, wval};
                lo       = {1'b0, a[HALF-1:0]} + {1'b0, wval[HALF-1:0]};
                res      = sum[XLEN-1:0];
                nflags.c = sum[XLEN];
                nflags.dc = lo[HALF];
                upd      = '1;
            end
            OP_SUB, OP_LSUB: begin
                sum      = {1'b0, a} + {1'b0, ~wval} + {{XLEN{1'b0}}, 1'b1};
                lo       = {1'b0, a[HALF-1:0]} + {1'b0, ~wval[HALF-1:0]} +
                           {{HALF{1'b0}}, 1'b1};
                res      = sum[XLEN-1:0];
                nflags.c = sum[XLEN];
                nflags.dc = lo[HALF];
                upd      = '1;
            end
            OP_DEC: begin
                res   = fval - XLEN'(1);
                upd.z = 1'b1;
            end
            OP_INC: begin
                res   = fval + XLEN'(1);
                upd.z = 1'b1;
            end
            OP_IOR, OP_LIOR: begin
                res   = a | wval;
                upd.z = 1'b1;
            end
            OP_AND, OP_LAND: begin
                res   = a & wval;
                upd.z = 1'b1;
            end
            OP_XOR, OP_LXOR: begin
                res   = a ^ wval;
                upd.z = 1'b1;
            end
            OP_MOV: upd.z = 1'b1;
            OP_COM: begin
                res   = ~fval;
                upd.z = 1'b1;
            end
            OP_DECSZ: begin
                res  = fval - XLEN'(1);
                skip = (res == '0);
            end
            OP_INCSZ: begin
                res  = fval + XLEN'(1);
                skip = (res == '0);
            end
            OP_RR: begin
                res      = {c_in, fval[XLEN-1:1]};
                nflags.c = fval[0];
                upd.c    = 1'b1;
            end
            OP_RL: begin
                res      = {fval[XLEN-2:0], c_in};
                nflags.c = fval[XLEN-1];
                upd.c    = 1'b1;
            end
            OP_SWAP: res = {fval[HALF-1:0], fval[XLEN-1:HALF]};
            OP_BCLR: res = fval & ~bmask;
            OP_BSET: res = fval | bmask;
            OP_BTSTC: begin
                wr_res = 1'b0;
                skip   = ~|(fval & bmask);
            end
            OP_BTSTS: begin
                wr_res = 1'b0;
                skip   = |(fval & bmask);
            end
            OP_LMOV: res = lit;
            default: wr_res = 1'b0;
        endcase
        nflags.z = (res == '0);
    end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int STATUS_ADDR = 3,
    parameter int FILE_DEPTH  = 1 << FADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [IW-1:0]      instr,
    input  logic [FADDR_W-1:0] rd_addr,
    output logic [XLEN-1:0]    rd_data,
    output logic [XLEN-1:0]    w_out,
    output logic [2:0]         flags_out,
    output logic               skip_req
);

    localparam logic [FADDR_W-1:0] STAT_A = FADDR_W'(STATUS_ADDR);

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    dec_t             dec;
    logic [XLEN-1:0]  w_q;
    flags_t           flags_q;
    flags_t           flags_d;
    flags_t           base_f;
    flags_t           alu_f;
    flags_t           alu_upd;
    logic [XLEN-1:0]  alu_res;
    logic             alu_wr;
    logic             alu_skip;
    logic [XLEN-1:0]  stat_byte;
    logic [XLEN-1:0]  mem_op;
    logic [XLEN-1:0]  mem_rd;
    logic [XLEN-1:0]  fval;
    logic             exec;
    logic             wr_w;
    logic             wr_f;
    logic             wr_stat;
    logic             wr_mem;
    logic             skip_q;

    acc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign stat_byte = XLEN'(flags_q);
    assign fval      = (dec.faddr == STAT_A) ? stat_byte : mem_op;

    acc_alu u_alu (
        .op     (dec.op),
        .bsel   (dec.bsel),
        .lit    (dec.lit),
        .fval   (fval),
        .wval   (w_q),
        .c_in   (flags_q.c),
        .res    (alu_res),
        .nflags (alu_f),
        .upd    (alu_upd),
        .wr_res (alu_wr),
        .skip   (alu_skip)
    );

    assign exec    = instr_valid && (state_q == ST_RUN);
    assign wr_w    = exec && alu_wr && !dec.to_file;
    assign wr_f    = exec && alu_wr && dec.to_file;
    assign wr_stat = wr_f && (dec.faddr == STAT_A);
    assign wr_mem  = wr_f && (dec.faddr != STAT_A);

    acc_regfile #(
        .DEPTH  (FILE_DEPTH),
        .DATA_W (XLEN)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_mem),
        .waddr   (dec.faddr),
        .wdata   (alu_res),
        .raddr_a (dec.faddr),
        .rdata_a (mem_op),
        .raddr_b (rd_addr),
        .rdata_b (mem_rd)
    );

    // Control machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (exec && alu_skip) state_d = ST_SQUASH;
            ST_SQUASH: if (instr_valid)      state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Flag merge: a byte written to the status address is the base,
    // the instruction's own flag updates take precedence.
    always_comb begin
        base_f    = wr_stat ? flags_t'(alu_res[2:0]) : flags_q;
        flags_d.c  = alu_upd.c  ? alu_f.c  : base_f.c;
        flags_d.dc = alu_upd.dc ? alu_f.dc : base_f.dc;
        flags_d.z  = alu_upd.z  ? alu_f.z  : base_f.z;
    end

    // Architectural outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q     <= '0;
            flags_q <= '0;
            skip_q  <= 1'b0;
        end else begin
            skip_q <= exec && alu_skip;
            if (wr_w) begin
                w_q <= alu_res;
            end
            if (exec) begin
                flags_q <= flags_d;
            end
        end
    end

    assign w_out     = w_q;
    assign flags_out = flags_q;
    assign skip_req  = skip_q;
    assign rd_data   = (rd_addr == STAT_A) ? stat_byte : mem_rd;

    // R10: an idle cycle holds W and flags
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(w_q) && $stable(flags_q)));

    // R9: a word arriving while a discard is pending changes nothing
    a_r9_squash_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && state_q == ST_SQUASH) |=>
            ($stable(w_q) && $stable(flags_q) && !skip_req));

    // R8: a skip request is always accompanied by a pending discard
    a_r8_skip_pending: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> (state_q == ST_SQUASH));

    // R5: nibble swap away from the status address leaves the flags alone
    a_r5_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.op == OP_SWAP && !(dec.to_file && dec.faddr == STAT_A))
            |=> $stable(flags_q));

    // R4: clearing W leaves zero in W and sets Z
    a_r4_clrw_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.op == OP_CLR && !dec.to_file) |=> (w_q == '0 && flags_q.z));

endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;

    logic        clk;
    logic        rst_n;
    logic        instr_valid;
    logic [13:0] instr;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [7:0]  w_out;
    logic [2:0]  flags_out;
    logic        skip_req;

    acc_exec_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .w_out       (w_out),
        .flags_out   (flags_out),
        .skip_req    (skip_req)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int nchk  = 0;
    int nfail = 0;

    logic [7:0] mmem [128];
    logic [7:0] mw;
    logic       mc, mdc, mz;
    logic       m_squash;
    logic       exp_skip;
    string      cur_tag;

    function automatic logic [7:0] mrd(input logic [6:0] a);
        return (a == 7'd3) ? {5'b0, mz, mdc, mc} : mmem[a];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic [13:0] ins);
        logic       wr, tofile, uc, udc, uz, nc, ndc, sk;
        logic [7:0] fv, r, a;
        logic [8:0] s;
        logic [4:0] lo;
        logic [6:0] f;
        wr = 0; tofile = ins[7]; uc = 0; udc = 0; uz = 0; nc = mc; ndc = mdc;
        sk = 0; r = 8'h00; s = '0; lo = '0;
        f  = ins[6:0];
        fv = mrd(f);
        if (!v) begin
            exp_skip = 0; cur_tag = "R10"; return;
        end
        if (m_squash) begin
            m_squash = 0; exp_skip = 0; cur_tag = "R9"; return;
        end
        cur_tag = "R10";
        unique case (ins[13:12])
            2'b00: begin
                wr = 1;
                case (ins[11:8])
                    4'h0: begin wr = ins[7]; r = mw; cur_tag = "R5"; end
                    4'h1: begin r = 0; uz = 1; cur_tag = "R4"; end
                    4'h2, 4'h7: begin
                        if (ins[11:8] == 4'h7) begin
                            s = {1'b0, fv} + {1'b0, mw};
                            lo = {1'b0, fv[3:0]} + {1'b0, mw[3:0]};
                        end else begin
                            s = {1'b0, fv} + {1'b0, ~mw} + 9'd1;
                            lo = {1'b0, fv[3:0]} + {1'b0, ~mw[3:0]} + 5'd1;
                        end
                        r = s[7:0]; nc = s[8]; ndc = lo[4];
                        uc = 1; udc = 1; uz = 1; cur_tag = "R3";
                    end
                    4'h3: begin r = fv - 1; uz = 1; cur_tag = "R4"; end
                    4'h4: begin r = fv | mw; uz = 1; cur_tag = "R4"; end
                    4'h5: begin r = fv & mw; uz = 1; cur_tag = "R4"; end
                    4'h6: begin r = fv ^ mw; uz = 1; cur_tag = "R4"; end
                    4'h8: begin r = fv; uz = 1; cur_tag = "R4"; end
                    4'h9: begin r = ~fv; uz = 1; cur_tag = "R4"; end
                    4'hA: begin r = fv + 1; uz = 1; cur_tag = "R4"; end
                    4'hB: begin r = fv - 1; sk = (r == 0); cur_tag = "R5"; end
                    4'hC: begin r = {mc, fv[7:1]}; nc = fv[0]; uc = 1; cur_tag = "R5"; end
                    4'hD: begin r = {fv[6:0], mc}; nc = fv[7]; uc = 1; cur_tag = "R5"; end
                    4'hE: begin r = {fv[3:0], fv[7:4]}; cur_tag = "R5"; end
                    default: begin r = fv + 1; sk = (r == 0); cur_tag = "R5"; end
                endcase
            end
            2'b01: begin
                cur_tag = "R6"; tofile = 1;
                case (ins[11:10])
                    2'b00: begin wr = 1; r = fv & ~(8'h01 << ins[9:7]); end
                    2'b01: begin wr = 1; r = fv | (8'h01 << ins[9:7]); end
                    2'b10: sk = !fv[ins[9:7]];
                    default: sk = fv[ins[9:7]];
                endcase
            end
            2'b11: begin
                a = ins[7:0]; tofile = 0; cur_tag = "R7";
                casez (ins[11:8])
                    4'b00??: begin wr = 1; r = a; end
                    4'b1000: begin wr = 1; r = a | mw; uz = 1; end
                    4'b1001: begin wr = 1; r = a & mw; uz = 1; end
                    4'b1010: begin wr = 1; r = a ^ mw; uz = 1; end
                    4'b110?, 4'b111?: begin
                        wr = 1;
                        if (ins[9]) begin
                            s = {1'b0, a} + {1'b0, mw};
                            lo = {1'b0, a[3:0]} + {1'b0, mw[3:0]};
                        end else begin
                            s = {1'b0, a} + {1'b0, ~mw} + 9'd1;
                            lo = {1'b0, a[3:0]} + {1'b0, ~mw[3:0]} + 5'd1;
                        end
                        r = s[7:0]; nc = s[8]; ndc = lo[4];
                        uc = 1; udc = 1; uz = 1; cur_tag = "R3";
                    end
                    default: cur_tag = "R10";
                endcase
            end
            default: cur_tag = "R10";
        endcase
        if (wr && tofile) begin
            if (f == 7'd3) {mz, mdc, mc} = r[2:0];
            else mmem[f] = r;
        end
        if (wr && !tofile) mw = r;
        if (uc)  mc  = nc;
        if (udc) mdc = ndc;
        if (uz)  mz  = (r == 8'h00);
        exp_skip = sk;
        if (sk) m_squash = 1;
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic apply(input logic v, input logic [13:0] ins);
        instr_valid = v;
        instr       = ins;
        rd_addr     = ins[6:0];
        model(v, ins);
        @(posedge clk);
        @(negedge clk);
        chk(cur_tag, "W", w_out, mw);
        chk(cur_tag, "flags", {5'b0, flags_out}, {5'b0, mz, mdc, mc});
        chk("R8", "skip", {7'b0, skip_req}, {7'b0, exp_skip});
        chk((ins[6:0] == 7'd3) ? "R11" : "R2", "file", rd_data, mrd(ins[6:0]));
    endtask

    function automatic logic [13:0] rand_instr();
        logic [31:0] x;
        logic [6:0]  f;
        x = $urandom;
        f = 7'($urandom % 8);
        case ($urandom % 8)
            0, 1, 2: return {2'b00, x[3:0], x[4], f};
            3:       return {2'b01, x[1:0], x[4:2], f};
            4, 5:    return {2'b11, x[11:0]};
            6:       return {2'b10, x[11:0]};
            default: return {2'b00, x[0] ? 4'hB : 4'hF, x[1], f};
        endcase
    endfunction

    bit done = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 0; instr_valid = 0; instr = '0; rd_addr = '0;
        for (int i = 0; i < 128; i++) mmem[i] = 8'h00;
        mw = 0; mc = 0; mdc = 0; mz = 0; m_squash = 0; exp_skip = 0; cur_tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "W", w_out, 8'h00);
        chk("R1", "flags", {5'b0, flags_out}, 8'h00);
        chk("R1", "skip", {7'b0, skip_req}, 8'h00);
        rd_addr = 7'd77; #1;
        chk("R1", "file", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Directed corner cases
        apply(1, 14'h3088);   // R7 move literal 0x88
        apply(1, 14'h3E88);   // R3 add literal: 0x10, C=1, DC=1
        apply(1, 14'h0085);   // R5 copy W to f5
        apply(1, 14'h3C10);   // R3 subtract literal: zero, no borrow
        apply(1, 14'h0D85);   // R5 rotate left through carry
        apply(1, 14'h0C05);   // R5 rotate right into W
        apply(1, 14'h3001);
        apply(1, 14'h0086);
        apply(1, 14'h0B86);   // R8 decrement-skip to zero
        apply(1, 14'h3E01);   // R9 discarded
        apply(0, 14'h3E01);   // R10 idle
        apply(1, 14'h3E01);   // executes normally
        apply(1, 14'h3007);
        apply(1, 14'h0083);   // R11 write flag byte
        apply(1, 14'h0783);   // R11 add into flag byte, own flags win
        apply(1, 14'h1403);   // R6 set C through address 3
        apply(1, 14'h0E85);   // R5 swap
        apply(1, 14'h1C03);   // R6/R8 test set -> skip
        apply(0, 14'h0000);   // R10 idle while discard pending
        apply(1, 14'h3FFF);   // R9 discarded
        apply(1, 14'h0100);   // R4 clear W
        apply(1, 14'h2000);   // R10 control-flow group ignored
        apply(1, 14'h3455);   // R10 unused literal encoding
        apply(1, 14'h0060);   // R10 no-operation

        for (int n = 0; n < 4000; n++) begin
            apply(($urandom % 8) != 0, rand_instr());
        end

        // R12: sweep the read port
        instr_valid = 0;
        for (int a = 0; a < 128; a++) begin
            rd_addr = 7'(a);
            #1;
            chk("R12", "file", rd_data, mrd(7'(a)));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule